// File: doc/BRIEF.md
# Register File and Data Memory Datapath

This block is a small datapath with no instruction sequencing. An array of general registers, a word-addressed data memory and an arithmetic unit are wired together, and every transfer is steered by strobes at the ports. A controller outside the block first fills the memory. It then copies memory words into registers, combines two registers in the arithmetic unit and writes the result into a third register. Last, it copies registers back into memory.

Two register read ports feed both the arithmetic unit and an equality comparator. The comparator's result is the only output. The memory write source is chosen by a select line: either the external data word or the register on the first read port. The register write source is also chosen by a select line: either the arithmetic result or the memory word at the current memory address. Memory reads are combinational. All writes take effect at the rising clock edge.

Top module: `rf_mem_datapath`

## Requirements
- R1: An asynchronous active-low reset sets every register to 0; after reset `eq_flag` is 1 for any pair of read addresses.
- R2: With `mem_we` high and `mem_src_reg` low, the memory word at `mem_addr` takes `ext_data` at the rising edge.
- R3: With `mem_we` high and `mem_src_reg` high, the memory word at `mem_addr` takes the register selected by `rd_a_sel`.
- R4: With `mem_we` low the memory is unchanged, and the word at `mem_addr` is readable combinationally in the same cycle.
- R5: With `reg_we` high and `reg_src_mem` low, the register at `wr_sel` takes the arithmetic result at the rising edge.
- R6: With `reg_we` high and `reg_src_mem` high, the register at `wr_sel` takes the memory word at `mem_addr`.
- R7: With `reg_we` and `reg_clr` both low, no register changes.
- R8: `reg_clr` high sets all registers to 0 at the rising edge and overrides a register write in the same cycle.
- R9: Operation codes are 000 add, 001 subtract (A minus B), 010 bitwise AND and 011 bitwise XOR, where A is the `rd_a_sel` register and B is the `rd_b_sel` register. Results wrap modulo 2^DATA_W.
- R10: Operation codes 100 to 111 give a result of 0.
- R11: `eq_flag` is 1 exactly when the registers at `rd_a_sel` and `rd_b_sel` hold equal values, and it follows the read addresses combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_sel | input | 3 | First register read address (A operand, memory store source) |
| rd_b_sel | input | 3 | Second register read address (B operand) |
| wr_sel | input | 3 | Register write address |
| reg_we | input | 1 | Register write strobe |
| reg_clr | input | 1 | Synchronous clear of all registers |
| reg_src_mem | input | 1 | Register write source: 0 arithmetic result, 1 memory word |
| alu_op | input | 3 | Arithmetic operation code |
| mem_addr | input | 4 | Data memory address |
| ext_data | input | 4 | External data word for memory writes |
| mem_we | input | 1 | Memory write strobe |
| mem_src_reg | input | 1 | Memory write source: 0 external data, 1 register A |
| eq_flag | output | 1 | Registers A and B are equal |

## Verification
`eq_flag` is combinational from the registers and read addresses, so its value is due within the same cycle. Every write, whether to a register or to memory, is due one rising edge after its strobe. The bench drives all inputs on the falling edge and lets one rising edge pass for each write. It drops the strobes on the next falling edge, then moves the read addresses and samples `eq_flag` a nanosecond later, with no edge in between. An exact register value is read out through the comparator: the probe value goes into a scratch memory word, is loaded into a scratch register, and is compared against the register under test. Each such probe takes two write cycles before its sample.

// File: rtl/rmd_pkg.sv
`timescale 1ns/1ps
package rmd_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_XOR = 3'b011
  } alu_op_e;

  typedef enum logic {
    RSRC_ALU = 1'b0,
    RSRC_MEM = 1'b1
  } reg_src_e;

  typedef enum logic {
    MSRC_EXT = 1'b0,
    MSRC_REG = 1'b1
  } mem_src_e;
endpackage

// File: rtl/rmd_alu.sv
`timescale 1ns/1ps
module rmd_alu
  import rmd_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_AND:  res_o = a_i & b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/rmd_regfile.sv
`timescale 1ns/1ps
module rmd_regfile #(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned REG_N  = 8,
  localparam int unsigned SEL_W = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [SEL_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SEL_W-1:0]  ra_i,
  input  logic [SEL_W-1:0]  rb_i,
  output logic [DATA_W-1:0] rda_o,
  output logic [DATA_W-1:0] rdb_o
);
  logic [REG_N-1:0][DATA_W-1:0] q;
  logic [REG_N-1:0][DATA_W-1:0] q_nxt;
  logic [REG_N-1:0]             q_en;

  for (genvar g = 0; g < REG_N; g++) begin : g_entry
    always_comb begin
      q_en[g]  = clr_i | (we_i & (waddr_i == SEL_W'(g)));
      q_nxt[g] = clr_i ? '0 : wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q[g] <= '0;
      else if (q_en[g])  q[g] <= q_nxt[g];
    end
  end

  assign rda_o = q[ra_i];
  assign rdb_o = q[rb_i];

  assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (q == '0));

  assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !clr_i) |=> (q[$past(waddr_i)] == $past(wdata_i)));

  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i && !clr_i) |=> $stable(q));
endmodule

// File: rtl/rmd_datamem.sv
`timescale 1ns/1ps
module rmd_datamem #(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned WORDS  = 16,
  localparam int unsigned ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [WORDS-1:0][DATA_W-1:0] mem;

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];

  assert_mem_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mem[$past(addr_i)] == $past(wdata_i)));

  assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mem));
endmodule

// File: rtl/rf_mem_datapath.sv
`timescale 1ns/1ps
module rf_mem_datapath
  import rmd_pkg::*;
#(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned REG_N  = 8,
  parameter int unsigned WORDS  = 16,
  localparam int unsigned SEL_W  = $clog2(REG_N),
  localparam int unsigned ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  rd_a_sel,
  input  logic [SEL_W-1:0]  rd_b_sel,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic              reg_we,
  input  logic              reg_clr,
  input  logic              reg_src_mem,
  input  logic [OP_W-1:0]   alu_op,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] ext_data,
  input  logic              mem_we,
  input  logic              mem_src_reg,
  output logic              eq_flag
);
  logic [DATA_W-1:0] opnd_a;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] alu_res;
  logic [DATA_W-1:0] mem_rd;
  logic [DATA_W-1:0] reg_wdata;
  logic [DATA_W-1:0] mem_wdata;

  always_comb begin
    reg_wdata = (reg_src_e'(reg_src_mem) == RSRC_MEM) ? mem_rd : alu_res;
    mem_wdata = (mem_src_e'(mem_src_reg) == MSRC_REG) ? opnd_a : ext_data;
  end

  rmd_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (reg_clr),
    .we_i    (reg_we),
    .waddr_i (wr_sel),
    .wdata_i (reg_wdata),
    .ra_i    (rd_a_sel),
    .rb_i    (rd_b_sel),
    .rda_o   (opnd_a),
    .rdb_o   (opnd_b)
  );

  rmd_alu #(.DATA_W(DATA_W)) i_alu (
    .op_i  (alu_op),
    .a_i   (opnd_a),
    .b_i   (opnd_b),
    .res_o (alu_res)
  );

  rmd_datamem #(.DATA_W(DATA_W), .WORDS(WORDS)) i_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (mem_wdata),
    .rdata_o (mem_rd)
  );

  assign eq_flag = (opnd_a == opnd_b);

  assert_store_from_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_src_reg) |=> (mem_rd == $past(opnd_a) || mem_addr != $past(mem_addr)));
endmodule

// File: tb/test_rf_mem_datapath.sv
`timescale 1ns/1ps
module test_rf_mem_datapath;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] rd_a_sel, rd_b_sel, wr_sel;
  logic       reg_we, reg_clr, reg_src_mem;
  logic [2:0] alu_op;
  logic [3:0] mem_addr;
  logic [3:0] ext_data;
  logic       mem_we, mem_src_reg;
  logic       eq_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] m_r   [8];
  logic [3:0] m_mem [16];

  always #5 clk = ~clk;

  rf_mem_datapath i_rf_mem_datapath (
    .clk(clk), .rst_n(rst_n), .rd_a_sel(rd_a_sel), .rd_b_sel(rd_b_sel),
    .wr_sel(wr_sel), .reg_we(reg_we), .reg_clr(reg_clr), .reg_src_mem(reg_src_mem),
    .alu_op(alu_op), .mem_addr(mem_addr), .ext_data(ext_data), .mem_we(mem_we),
    .mem_src_reg(mem_src_reg), .eq_flag(eq_flag)
  );

  function automatic logic [3:0] alu_f(input logic [2:0] op, input logic [3:0] a, input logic [3:0] b);
    case (op)
      3'd0:    return a + b;
      3'd1:    return a - b;
      3'd2:    return a & b;
      3'd3:    return a ^ b;
      default: return 4'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: eq_flag=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(input logic [2:0] ra, input logic [2:0] rb, input logic [2:0] dst,
                      input logic rwe, input logic clr, input logic rsrc, input logic [2:0] op,
                      input logic [3:0] addr, input logic [3:0] din, input logic mwe, input logic msrc);
    logic [3:0] new_mem, new_reg;
    @(negedge clk);
    rd_a_sel = ra; rd_b_sel = rb; wr_sel = dst; reg_we = rwe; reg_clr = clr;
    reg_src_mem = rsrc; alu_op = op; mem_addr = addr; ext_data = din;
    mem_we = mwe; mem_src_reg = msrc;
    new_mem = msrc ? m_r[ra] : din;
    new_reg = rsrc ? m_mem[addr] : alu_f(op, m_r[ra], m_r[rb]);
    @(posedge clk);
    if (mwe) m_mem[addr] = new_mem;
    if (clr) for (int i = 0; i < 8; i++) m_r[i] = 4'd0;
    else if (rwe) m_r[dst] = new_reg;
    @(negedge clk);
    reg_we = 1'b0; reg_clr = 1'b0; mem_we = 1'b0;
  endtask

  task automatic cmp(input logic [2:0] ra, input logic [2:0] rb, input string tag);
    rd_a_sel = ra; rd_b_sel = rb;
    #1;
    chk(tag, eq_flag, (m_r[ra] == m_r[rb]));
  endtask

  task automatic cmp_all(input string tag);
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++) cmp(a[2:0], b[2:0], tag);
  endtask

  // exact value probe: v -> mem[15] -> scratch register, compared with register k
  task automatic probe(input logic [2:0] k, input logic [3:0] v, input string tag);
    logic [2:0] sc;
    sc = (k == 3'd7) ? 3'd6 : 3'd7;
    step(0, 0, 0, 0, 0, 0, 0, 4'd15, v, 1, 0);
    step(0, 0, sc, 1, 0, 1, 0, 4'd15, 0, 0, 0);
    rd_a_sel = k; rd_b_sel = sc;
    #1;
    chk(tag, eq_flag, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    rd_a_sel = 0; rd_b_sel = 0; wr_sel = 0; reg_we = 0; reg_clr = 0; reg_src_mem = 0;
    alu_op = 0; mem_addr = 0; ext_data = 0; mem_we = 0; mem_src_reg = 0;
    for (int i = 0; i < 8; i++) m_r[i] = 4'd0;
    for (int i = 0; i < 16; i++) m_mem[i] = 4'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    cmp_all("R1");
    probe(3'd0, 4'd0, "R1");

    // R2: fill memory from the external word
    for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, 0, 0, i[3:0], 4'((i * 7 + 9) % 16), 1, 0);
    // R6: load registers from memory, then probe exact values
    for (int i = 0; i < 8; i++) step(0, 0, i[2:0], 1, 0, 1, 0, i[3:0], 0, 0, 0);
    probe(3'd0, 4'd9, "R6");
    probe(3'd3, 4'd14, "R6");
    probe(3'd2, 4'd7, "R6");
    cmp_all("R11");

    // R9: each operation into R5, with A = R0 (9), B = R3 (14)
    step(0, 3, 5, 1, 0, 0, 3'd0, 0, 0, 0, 0); probe(3'd5, 4'd7, "R9 add wrap");
    step(0, 3, 5, 1, 0, 0, 3'd1, 0, 0, 0, 0); probe(3'd5, 4'd11, "R9 sub");
    step(3, 0, 5, 1, 0, 0, 3'd1, 0, 0, 0, 0); probe(3'd5, 4'd5, "R9 sub reversed");
    step(0, 3, 5, 1, 0, 0, 3'd2, 0, 0, 0, 0); probe(3'd5, 4'd8, "R9 and");
    step(0, 3, 5, 1, 0, 0, 3'd3, 0, 0, 0, 0); probe(3'd5, 4'd7, "R9 xor");
    // R10: undefined codes give 0
    step(0, 3, 5, 1, 0, 0, 3'd5, 0, 0, 0, 0); probe(3'd5, 4'd0, "R10");
    step(0, 3, 4, 1, 0, 0, 3'd7, 0, 0, 0, 0); probe(3'd4, 4'd0, "R10");

    // R3: store R3 (14) into word 12 from the register path
    step(3, 0, 0, 0, 0, 0, 0, 4'd12, 4'd1, 1, 1);
    step(0, 0, 5, 1, 0, 1, 0, 4'd12, 0, 0, 0);
    probe(3'd5, 4'd14, "R3");
    // R4: write strobe low leaves word 12, same-cycle read loads it
    step(0, 0, 4, 1, 0, 1, 0, 4'd12, 4'd1, 0, 0);
    probe(3'd4, 4'd14, "R4");
    // R2: direct external write then read back
    step(0, 0, 0, 0, 0, 0, 0, 4'd13, 4'd6, 1, 0);
    step(0, 0, 5, 1, 0, 1, 0, 4'd13, 0, 0, 0);
    probe(3'd5, 4'd6, "R2");
    // R7: register write strobe low
    step(0, 0, 0, 0, 0, 1, 0, 4'd13, 0, 0, 0);
    probe(3'd0, 4'd9, "R7");
    // R8: clear beats a concurrent write
    step(0, 0, 2, 1, 1, 1, 0, 4'd13, 0, 0, 0);
    cmp_all("R8");
    probe(3'd2, 4'd0, "R8");

    // constrained random traffic
    for (int n = 0; n < 400; n++) begin
      step($urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
           $urandom_range(0, 1), ($urandom_range(0, 15) == 0), $urandom_range(0, 1),
           $urandom_range(0, 7), $urandom_range(0, 15), $urandom_range(0, 15),
           $urandom_range(0, 1), $urandom_range(0, 1));
      for (int j = 0; j < 4; j++) cmp($urandom_range(0, 7), $urandom_range(0, 7), "R11 random");
    end
    for (int k = 0; k < 8; k++) probe(k[2:0], m_r[k], "R5 random final");

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule